// File: doc/BRIEF.md
# Mode-Dependent Pin Function Controller

This block decides what two shared port pins carry on a small bus-interface controller. A three-bit control register, written through a masked register-bus port, holds a bus-strobe enable, a calibration-output enable and a select between a data-enable strobe and an inverted bus clock. A combinational router then assigns a function to each pin from those bits, the operating mode and a no-data-bus-enable control input. Each pin can carry general-purpose I/O, the internal read/write strobe, the calibration reference, the external data-enable signal or the inverted E clock.

Two of the bits are guarded by a small per-bit state machine with three states. FRESH is the state after reset. LOCKED is reached from FRESH when a write arrives in a normal mode, and that write is taken. OPEN is reached from FRESH when a write arrives in a special mode, and that write is dropped. In LOCKED every later write is dropped. In OPEN every later write is taken. A write only counts for a bit when that bit's mask bit is set. The calibration bit has no guard.

Top module: `pin_ctrl_top`

## Requirements
- R1: In a normal mode (mode code 0 = single-chip, 2 = normal expanded), register bits 0 (strobe enable) and 2 (clock select) take the first masked write after reset, and every later write to them is ignored.
- R2: In a special mode (mode code 1 = peripheral, 3 = special expanded), the first masked write after reset to bit 0 or bit 2 is ignored but still used up. Every later masked write to that bit is taken.
- R3: Bit 1 (calibration enable) takes every masked write in any mode. `rd_data` always shows all three bits, with bit n at position n.
- R4: A write whose mask bit n is 0 neither changes bit n nor uses up that bit's first write.
- R5: After reset all three register bits read 0.
- R6: Pin index 0 carries `rw_int` when bit 0 is 1 and the mode is not single-chip. Otherwise it carries `gpio_do[0]`.
- R7: In single-chip or peripheral mode, or when `nodbe` is 1, pin index 1 carries `cal_ref` if bit 1 is 1 and `gpio_do[1]` if bit 1 is 0.
- R8: In an expanded mode with `nodbe` at 0, pin index 1 carries `ext_dbe` when bit 2 is 0. When bit 2 is 1 it carries the exact inverse of `e_clk`, so it stays high for as long as `e_clk` stays low.
- R9: A pin that carries any function other than general-purpose I/O has its output enable forced to 1. A general-purpose I/O pin has its output enable taken from `gpio_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Operating mode: 0 single-chip, 1 peripheral, 2 normal expanded, 3 special expanded |
| nodbe | input | 1 | No-data-bus-enable control |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 3 | Write data |
| wr_mask | input | 3 | Per-bit write mask |
| rd_data | output | 3 | Current register value |
| e_clk | input | 1 | Bus clock E |
| ext_dbe | input | 1 | External data-enable signal |
| cal_ref | input | 1 | Calibration reference |
| rw_int | input | 1 | Internal read/write strobe |
| gpio_do | input | 2 | GPIO data for pin index 0 and pin index 1 |
| gpio_oe | input | 2 | GPIO direction (1 = drive) for each pin |
| pin_do | output | 2 | Resolved pin drive value |
| pin_oe | output | 2 | Resolved pin output enable |

## Verification
The bench looks for the following faults:
- A guard that does not tell normal modes from special modes either takes the first write in a special mode or keeps accepting writes in a normal mode. Repeated full-mask writes of alternating values in all four modes expose both cases.
- Writes with an empty mask, or a mask that covers only one guarded bit, come before the real writes. A design that used up the single write without checking the mask would then freeze the wrong bit.
- Each mode is run with `nodbe` at both levels and with `e_clk`, `ext_dbe` and `cal_ref` random on every cycle. This catches a router whose priority between mode and `nodbe` is in the wrong order, or whose inverted clock is not a pure inversion.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

    typedef enum logic [1:0] {
        MD_SINGLE = 2'd0,
        MD_PERIPH = 2'd1,
        MD_NEXP   = 2'd2,
        MD_SEXP   = 2'd3
    } op_mode_t;

    typedef enum logic [1:0] {
        WP_FRESH  = 2'd0,
        WP_LOCKED = 2'd1,
        WP_OPEN   = 2'd2
    } wp_state_t;

    typedef enum logic [1:0] {
        P7_GPIO  = 2'd0,
        P7_CAL   = 2'd1,
        P7_DBE   = 2'd2,
        P7_NECLK = 2'd3
    } p7_fn_t;

    function automatic logic is_special(op_mode_t m);
        return (m == MD_PERIPH) || (m == MD_SEXP);
    endfunction

    function automatic logic is_expanded(op_mode_t m);
        return (m == MD_NEXP) || (m == MD_SEXP);
    endfunction

endpackage

// File: rtl/pin_wlatch.sv
module pin_wlatch
    import pinmux_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  logic special,
    input  logic d,
    output logic q
);

    wp_state_t st, st_nx;
    logic      q_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= WP_FRESH;
            q  <= 1'b0;
        end else begin
            st <= st_nx;
            q  <= q_nx;
        end
    end

    always_comb begin
        st_nx = st;
        q_nx  = q;
        if (wr_hit) begin
            unique case (st)
                WP_FRESH: begin
                    if (special) begin
                        st_nx = WP_OPEN;
                    end else begin
                        st_nx = WP_LOCKED;
                        q_nx  = d;
                    end
                end
                WP_LOCKED: begin
                    st_nx = WP_LOCKED;
                end
                WP_OPEN: begin
                    q_nx = d;
                end
                default: begin
                    st_nx = WP_FRESH;
                end
            endcase
        end
    end

    // R1: once locked, further writes leave the bit alone
    p_locked_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && st == WP_LOCKED) |=> $stable(q));

    // R2: first write in a special mode is dropped
    p_special_first_dropped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && st == WP_FRESH && special) |=> $stable(q));

    // R2: after the dropped write, every write is taken
    p_open_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && st == WP_OPEN) |=> (q == $past(d)));

endmodule

// File: rtl/pin_route.sv
module pin_route
    import pinmux_pkg::*;
(
    input  op_mode_t   mode,
    input  logic       nodbe,
    input  logic       strobe_en,
    input  logic       cal_en,
    input  logic       clk_sel,
    input  logic       e_clk,
    input  logic       ext_dbe,
    input  logic       cal_ref,
    input  logic       rw_int,
    input  logic [1:0] gpio_do,
    input  logic [1:0] gpio_oe,
    output logic [1:0] pin_do,
    output logic [1:0] pin_oe
);

    p7_fn_t p7_fn;
    logic   p2_special;

    assign p2_special = strobe_en && (mode != MD_SINGLE);

    always_comb begin
        if (!is_expanded(mode) || nodbe) begin
            p7_fn = cal_en ? P7_CAL : P7_GPIO;
        end else begin
            p7_fn = clk_sel ? P7_NECLK : P7_DBE;
        end
    end

    always_comb begin
        pin_do[0] = p2_special ? rw_int : gpio_do[0];
        pin_oe[0] = p2_special ? 1'b1   : gpio_oe[0];
        unique case (p7_fn)
            P7_GPIO:  begin pin_do[1] = gpio_do[1]; pin_oe[1] = gpio_oe[1]; end
            P7_CAL:   begin pin_do[1] = cal_ref;    pin_oe[1] = 1'b1;       end
            P7_DBE:   begin pin_do[1] = ext_dbe;    pin_oe[1] = 1'b1;       end
            P7_NECLK: begin pin_do[1] = ~e_clk;     pin_oe[1] = 1'b1;       end
            default:  begin pin_do[1] = gpio_do[1]; pin_oe[1] = gpio_oe[1]; end
        endcase
    end

endmodule

// File: rtl/pin_ctrl_top.sv
module pin_ctrl_top
    import pinmux_pkg::*;
#(
    parameter int REG_W      = 3,
    parameter int STROBE_BIT = 0,
    parameter int CAL_BIT    = 1,
    parameter int SEL_BIT    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             nodbe,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic [REG_W-1:0] wr_mask,
    output logic [REG_W-1:0] rd_data,
    input  logic             e_clk,
    input  logic             ext_dbe,
    input  logic             cal_ref,
    input  logic             rw_int,
    input  logic [1:0]       gpio_do,
    input  logic [1:0]       gpio_oe,
    output logic [1:0]       pin_do,
    output logic [1:0]       pin_oe
);

    op_mode_t         md;
    logic             special;
    logic [REG_W-1:0] hit;
    logic [REG_W-1:0] bits;

    assign md      = op_mode_t'(mode);
    assign special = is_special(md);
    assign hit     = wr_mask & {REG_W{wr_en}};

    for (genvar g = 0; g < REG_W; g++) begin : g_bit
        if (g == CAL_BIT) begin : g_free
            logic r;
            always_ff @(posedge clk) begin
                if (!rst_n)      r <= 1'b0;
                else if (hit[g]) r <= wr_data[g];
            end
            assign bits[g] = r;
        end else begin : g_guard
            pin_wlatch u_wl (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_hit (hit[g]),
                .special(special),
                .d      (wr_data[g]),
                .q      (bits[g])
            );
        end
    end

    assign rd_data = bits;

    pin_route u_route (
        .mode     (md),
        .nodbe    (nodbe),
        .strobe_en(bits[STROBE_BIT]),
        .cal_en   (bits[CAL_BIT]),
        .clk_sel  (bits[SEL_BIT]),
        .e_clk    (e_clk),
        .ext_dbe  (ext_dbe),
        .cal_ref  (cal_ref),
        .rw_int   (rw_int),
        .gpio_do  (gpio_do),
        .gpio_oe  (gpio_oe),
        .pin_do   (pin_do),
        .pin_oe   (pin_oe)
    );

    // R3: calibration enable follows every masked write
    p_cal_any_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_mask[CAL_BIT]) |=> (rd_data[CAL_BIT] == $past(wr_data[CAL_BIT])));

    // R4: an unmasked bit keeps its value
    p_unmasked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_mask == '0) |=> $stable(rd_data));

    // R6: single-chip leaves pin index 0 as plain GPIO
    p_single_gpio_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (md == MD_SINGLE) |-> (pin_do[0] == gpio_do[0] && pin_oe[0] == gpio_oe[0]));

    // R8: inverted clock is a pure inversion of E
    p_inv_clk_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_expanded(md) && !nodbe && rd_data[SEL_BIT]) |-> (pin_do[1] == !e_clk));

    // R9: strobe function forces the driver on
    p_strobe_drives_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (md != MD_SINGLE && rd_data[STROBE_BIT]) |-> pin_oe[0]);

endmodule

// File: tb/pin_ctrl_top_tb_top.sv
module pin_ctrl_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       nodbe = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_data = 3'd0;
    logic [2:0] wr_mask = 3'd0;
    logic [2:0] rd_data;
    logic       e_clk = 1'b0, ext_dbe = 1'b0, cal_ref = 1'b0, rw_int = 1'b0;
    logic [1:0] gpio_do = 2'd0, gpio_oe = 2'd0;
    logic [1:0] pin_do, pin_oe;

    int total = 0;
    int bad = 0;

    // reference model state
    int m_val [3];
    int m_used [3];

    always #5 clk = ~clk;

    pin_ctrl_top dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .nodbe(nodbe),
        .wr_en(wr_en), .wr_data(wr_data), .wr_mask(wr_mask), .rd_data(rd_data),
        .e_clk(e_clk), .ext_dbe(ext_dbe), .cal_ref(cal_ref), .rw_int(rw_int),
        .gpio_do(gpio_do), .gpio_oe(gpio_oe), .pin_do(pin_do), .pin_oe(pin_oe)
    );

    task automatic chk(input int act, input int exp, input string tag);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (mode=%0d nodbe=%0d t=%0t)",
                     tag, act, exp, mode, nodbe, $time);
        end
    endtask

    task automatic check_all();
        int exp_rd;
        int d0, o0, d1, o1;
        bit single, periph, use_cal;
        string t7;
        exp_rd = m_val[0] + 2 * m_val[1] + 4 * m_val[2];
        chk(rd_data, exp_rd, "R1 R2 R3 R4 R5 register");
        single = (mode == 2'd0);
        periph = (mode == 2'd1);
        if (!single && m_val[0] == 1) begin d0 = rw_int; o0 = 1; end
        else begin d0 = gpio_do[0]; o0 = gpio_oe[0]; end
        use_cal = single || periph || nodbe;
        if (use_cal) begin
            t7 = "R7 pin1 value";
            if (m_val[1] == 1) begin d1 = cal_ref; o1 = 1; end
            else begin d1 = gpio_do[1]; o1 = gpio_oe[1]; end
        end else begin
            t7 = "R8 pin1 value";
            o1 = 1;
            d1 = (m_val[2] == 1) ? (e_clk ? 0 : 1) : ext_dbe;
        end
        chk(pin_do[0], d0, "R6 pin0 value");
        chk(pin_do[1], d1, t7);
        chk(pin_oe[0], o0, "R9 pin0 enable");
        chk(pin_oe[1], o1, "R9 pin1 enable");
    endtask

    task automatic model_write();
        bit spec;
        spec = (mode == 2'd1) || (mode == 2'd3);
        if (!wr_en) return;
        for (int i = 0; i < 3; i++) begin
            if (wr_mask[i]) begin
                if (i == 1) m_val[i] = wr_data[i];
                else if (m_used[i] == 0) begin
                    m_used[i] = 1;
                    if (!spec) m_val[i] = wr_data[i];
                end else if (spec) m_val[i] = wr_data[i];
            end
        end
    endtask

    task automatic step(input logic we, input logic [2:0] d, input logic [2:0] m);
        @(negedge clk);
        wr_en = we; wr_data = d; wr_mask = m;
        e_clk = 1'($urandom); ext_dbe = 1'($urandom);
        cal_ref = 1'($urandom); rw_int = 1'($urandom);
        gpio_do = 2'($urandom); gpio_oe = 2'($urandom);
        #1 check_all();
        @(posedge clk);
        if (rst_n) model_write();
    endtask

    task automatic do_reset(input logic [1:0] md);
        @(negedge clk);
        rst_n = 1'b0; mode = md; wr_en = 1'b0;
        for (int i = 0; i < 3; i++) begin m_val[i] = 0; m_used[i] = 0; end
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_mode(input logic [1:0] md);
        do_reset(md);
        for (int n = 0; n < 2; n++) begin
            nodbe = n[0];
            // R5 reset values visible
            step(1'b0, 3'b111, 3'b111);
            step(1'b0, 3'b111, 3'b111);
        end
        nodbe = 1'b0;
        // R4: empty mask, then mask covering only bit 0
        step(1'b1, 3'b111, 3'b000);
        step(1'b1, 3'b111, 3'b001);
        step(1'b1, 3'b000, 3'b001);
        // bit 2 still unused: R1/R2 first write
        step(1'b1, 3'b111, 3'b100);
        step(1'b1, 3'b111, 3'b111);
        step(1'b1, 3'b000, 3'b111);
        step(1'b1, 3'b111, 3'b111);
        // R3 cal toggles
        step(1'b1, 3'b000, 3'b010);
        step(1'b1, 3'b010, 3'b010);
        for (int k = 0; k < 24; k++) begin
            nodbe = k[2];
            step(1'b0, 3'b000, 3'b000);
        end
        step(1'b1, 3'b101, 3'b111);
        for (int k = 0; k < 24; k++) begin
            nodbe = k[3];
            step(1'b0, 3'b000, 3'b000);
        end
        step(1'b1, 3'b000, 3'b110);
        // R8: idle bus, E low for many cycles
        nodbe = 1'b0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            wr_en = 1'b0; e_clk = 1'b0;
            #1 check_all();
        end
        for (int k = 0; k < 16; k++) begin
            nodbe = k[1];
            step(1'b0, 3'b000, 3'b000);
        end
    endtask

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) begin m_val[i] = 0; m_used[i] = 0; end
        run_mode(2'd0);
        run_mode(2'd1);
        run_mode(2'd2);
        run_mode(2'd3);
        run_mode(2'd3);
        run_mode(2'd2);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule